// File: doc/BRIEF.md
# Configurable Digital Pin Data Path

This block carries the digital signals of a single I/O pin between the pad and the core logic. A 13-bit configuration word sets how it works. A 3-bit source code chooses what the core sees on its input line. The choices are the pin's own level, the level of its odd/even partner pin, a Schmitt-filtered copy of either one, or the result of an analogue "own pin above partner pin" comparison. The same code also chooses whether the pad is driven from the core's output line or from the core-facing input value (loopback). The Schmitt and comparator results arrive here as ready-made digital inputs.

Three single-bit controls refine that path. One inverts the input value, one inverts the pad value, and one adds a retiming register in each direction. The core's direction signal enables the pad driver. Two 3-bit drive-strength codes go out unchanged to the analogue pad cell. When the code for the level currently being driven means "float", the driver enable is forced off.

Top module: `pin_digital_path`

## Requirements
- R1: While reset is asserted the retiming registers hold 0. With retiming on, source code 000 and no inversion, both coreIn and padOut read 0 whatever the pins and coreOut carry.
- R2: Source codes 000 and 001 give coreIn the own-pin level (pinSelf). Code 010 gives coreIn the partner-pin level (pinPartner).
- R3: Source codes 011 and 100 give coreIn the own-pin Schmitt input (schmSelf). Code 101 gives coreIn the partner Schmitt input (schmPartner).
- R4: Source codes 110 and 111 give coreIn the comparator input cmpGt.
- R5: Source codes 000, 011 and 110 drive padOut from coreOut. Codes 001, 010, 100, 101 and 111 drive padOut from coreIn.
- R6: Config bit 7 inverts the selected input value before it reaches coreIn.
- R7: Config bit 6 inverts the value sent to padOut, whether it comes from coreOut or from the loopback.
- R8: With config bit 8 set, coreIn shows the input value of the previous clock, and padOut from coreOut shows the previous clock's coreOut (after bit 6 inversion). Loopback uses the already retimed coreIn with no second register. Both registers load on every clock, whatever the state of bit 8.
- R9: padOe is coreDir AND NOT float. Float is true when the drive code for the current padOut level is 111: driveHigh when padOut is 1, driveLow when padOut is 0.
- R10: driveHigh equals config bits 5:3 and driveLow equals config bits 2:0, in the same cycle.
- R11: Config bit 12 (the mode bit, 0 in digital mode) has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWord | input | 13 | Configuration word: [12] mode, [11:9] source code, [8] retime, [7] invert input, [6] invert output, [5:3] high drive, [2:0] low drive |
| pinSelf | input | 1 | Logic level of this pin |
| pinPartner | input | 1 | Logic level of the odd/even partner pin |
| schmSelf | input | 1 | Schmitt-filtered level of this pin |
| schmPartner | input | 1 | Schmitt-filtered level of the partner pin |
| cmpGt | input | 1 | Comparator result, this pin above partner pin |
| coreOut | input | 1 | Output value from the core |
| coreDir | input | 1 | Output enable request from the core |
| coreIn | output | 1 | Input value presented to the core |
| padOut | output | 1 | Value driven onto the pad |
| padOe | output | 1 | Pad driver enable |
| driveHigh | output | 3 | Drive-strength code for a high level |
| driveLow | output | 3 | Drive-strength code for a low level |

## Verification
The only state in this block is the two retiming registers. A wrong value in either one shows up on coreIn or padOut in the first cycle that retiming is on, and through padOe when a float code applies. A mistake in decoding the source code shows up at once as a mismatch on coreIn or padOut for that code and input pattern. The bench therefore compares every output against its model on every clock. This catches a register that skips a load while retiming is off, which would show as a stale value one cycle after retiming is switched on.

// File: rtl/pin_path_pkg.sv
package pin_path_pkg;
  localparam int CFG_W      = 13;
  localparam int DRV_W      = 3;
  localparam int MODE_W     = 3;
  localparam int LO_LSB     = 0;
  localparam int HI_LSB     = LO_LSB + DRV_W;
  localparam int OINV_BIT   = HI_LSB + DRV_W;
  localparam int IINV_BIT   = OINV_BIT + 1;
  localparam int RETIME_BIT = IINV_BIT + 1;
  localparam int MODE_LSB   = RETIME_BIT + 1;
  localparam logic [DRV_W-1:0] DRV_FLOAT = '1;

  typedef enum logic [1:0] {
    SRC_OWN  = 2'd0,
    SRC_PAIR = 2'd1,
    SRC_CMP  = 2'd2
  } srcSelT;

  typedef struct packed {
    srcSelT src;
    logic   schmitt;
    logic   loopback;
    logic   retime;
    logic   invIn;
    logic   invOut;
    logic   floatHi;
    logic   floatLo;
  } pathStrobeT;
endpackage

// File: rtl/pin_path_ctrl.sv
module pin_path_ctrl
  import pin_path_pkg::*;
(
  input  logic [CFG_W-1:0] cfgWord,
  output pathStrobeT       strobe,
  output logic [DRV_W-1:0] driveHigh,
  output logic [DRV_W-1:0] driveLow
);
  logic [MODE_W-1:0] modeCode;

  assign modeCode  = cfgWord[MODE_LSB +: MODE_W];
  assign driveHigh = cfgWord[HI_LSB +: DRV_W];
  assign driveLow  = cfgWord[LO_LSB +: DRV_W];

  always_comb begin
    strobe          = '0;
    strobe.retime   = cfgWord[RETIME_BIT];
    strobe.invIn    = cfgWord[IINV_BIT];
    strobe.invOut   = cfgWord[OINV_BIT];
    strobe.floatHi  = (driveHigh == DRV_FLOAT);
    strobe.floatLo  = (driveLow == DRV_FLOAT);
    unique case (modeCode)
      3'b000: begin strobe.src = SRC_OWN;  strobe.schmitt = 1'b0; strobe.loopback = 1'b0; end
      3'b001: begin strobe.src = SRC_OWN;  strobe.schmitt = 1'b0; strobe.loopback = 1'b1; end
      3'b010: begin strobe.src = SRC_PAIR; strobe.schmitt = 1'b0; strobe.loopback = 1'b1; end
      3'b011: begin strobe.src = SRC_OWN;  strobe.schmitt = 1'b1; strobe.loopback = 1'b0; end
      3'b100: begin strobe.src = SRC_OWN;  strobe.schmitt = 1'b1; strobe.loopback = 1'b1; end
      3'b101: begin strobe.src = SRC_PAIR; strobe.schmitt = 1'b1; strobe.loopback = 1'b1; end
      3'b110: begin strobe.src = SRC_CMP;  strobe.schmitt = 1'b0; strobe.loopback = 1'b0; end
      default: begin strobe.src = SRC_CMP; strobe.schmitt = 1'b0; strobe.loopback = 1'b1; end
    endcase
  end
endmodule

// File: rtl/pin_path_data.sv
module pin_path_data
  import pin_path_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  pathStrobeT strobe,
  input  logic       pinSelf,
  input  logic       pinPartner,
  input  logic       schmSelf,
  input  logic       schmPartner,
  input  logic       cmpGt,
  input  logic       coreOut,
  input  logic       coreDir,
  output logic       coreIn,
  output logic       padOut,
  output logic       padOe
);
  logic rawIn;
  logic inNow;
  logic outNow;
  logic inReg;
  logic outReg;
  logic pastValid;

  always_comb begin
    unique case (strobe.src)
      SRC_OWN:  rawIn = strobe.schmitt ? schmSelf : pinSelf;
      SRC_PAIR: rawIn = strobe.schmitt ? schmPartner : pinPartner;
      SRC_CMP:  rawIn = cmpGt;
      default:  rawIn = 1'b0;
    endcase
  end

  assign inNow  = rawIn ^ strobe.invIn;
  assign outNow = coreOut ^ strobe.invOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReg     <= 1'b0;
      outReg    <= 1'b0;
      pastValid <= 1'b0;
    end else begin
      inReg     <= inNow;
      outReg    <= outNow;
      pastValid <= 1'b1;
    end
  end

  assign coreIn = strobe.retime ? inReg : inNow;
  assign padOut = strobe.loopback ? (coreIn ^ strobe.invOut)
                                  : (strobe.retime ? outReg : outNow);
  assign padOe  = coreDir & ~(padOut ? strobe.floatHi : strobe.floatLo);

  AST_RETIME_IN_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && strobe.retime) |-> (coreIn == $past(inNow))); // R8
  AST_RETIME_OUT_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && strobe.retime && !strobe.loopback) |-> (padOut == $past(outNow))); // R8
  AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rstN)
    !coreDir |-> !padOe); // R9
  AST_LOOP_FOLLOWS_IN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loopback && !strobe.invOut) |-> (padOut == coreIn)); // R5
endmodule

// File: rtl/pin_digital_path.sv
module pin_digital_path
  import pin_path_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             pinSelf,
  input  logic             pinPartner,
  input  logic             schmSelf,
  input  logic             schmPartner,
  input  logic             cmpGt,
  input  logic             coreOut,
  input  logic             coreDir,
  output logic             coreIn,
  output logic             padOut,
  output logic             padOe,
  output logic [DRV_W-1:0] driveHigh,
  output logic [DRV_W-1:0] driveLow
);
  pathStrobeT strobe;

  pin_path_ctrl ctrl_i (
    .cfgWord   (cfgWord),
    .strobe    (strobe),
    .driveHigh (driveHigh),
    .driveLow  (driveLow)
  );

  pin_path_data data_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .pinSelf     (pinSelf),
    .pinPartner  (pinPartner),
    .schmSelf    (schmSelf),
    .schmPartner (schmPartner),
    .cmpGt       (cmpGt),
    .coreOut     (coreOut),
    .coreDir     (coreDir),
    .coreIn      (coreIn),
    .padOut      (padOut),
    .padOe       (padOe)
  );

  AST_DRIVE_FORWARD: assert property (@(posedge clk) disable iff (!rstN)
    (driveHigh == cfgWord[HI_LSB +: DRV_W]) && (driveLow == cfgWord[LO_LSB +: DRV_W])); // R10
  AST_FLOAT_BOTH_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgWord[HI_LSB +: DRV_W] == DRV_FLOAT) && (cfgWord[LO_LSB +: DRV_W] == DRV_FLOAT)) |-> !padOe); // R9
  AST_PLAIN_OWN_PIN: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgWord[MODE_LSB +: MODE_W] == 3'b000) && !cfgWord[RETIME_BIT] && !cfgWord[IINV_BIT])
      |-> (coreIn == pinSelf)); // R2
endmodule

// File: tb/pin_digital_path_tb.sv
module pin_digital_path_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] cfgWord = '0;
  logic        pinSelf = 0, pinPartner = 0, schmSelf = 0, schmPartner = 0, cmpGt = 0;
  logic        coreOut = 0, coreDir = 0;
  logic        coreIn, padOut, padOe;
  logic [2:0]  driveHigh, driveLow;

  int testCount = 0;
  int failCount = 0;
  bit modelIn = 0;
  bit modelOut = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_digital_path dut_i (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord),
    .pinSelf(pinSelf), .pinPartner(pinPartner), .schmSelf(schmSelf),
    .schmPartner(schmPartner), .cmpGt(cmpGt), .coreOut(coreOut), .coreDir(coreDir),
    .coreIn(coreIn), .padOut(padOut), .padOe(padOe),
    .driveHigh(driveHigh), .driveLow(driveLow)
  );

  task automatic check(string tag, string what, int actual, int expected);
    testCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s %s actual=%0d expected=%0d cfg=%b", tag, what, actual, expected, cfgWord);
    end
  endtask

  function automatic bit selSource(int code);
    case (code)
      0, 1:    return pinSelf;
      2:       return pinPartner;
      3, 4:    return schmSelf;
      5:       return schmPartner;
      default: return cmpGt;
    endcase
  endfunction

  function automatic bit isLoop(int code);
    return (code == 1) || (code == 2) || (code == 4) || (code == 5) || (code == 7);
  endfunction

  task automatic driveRandomPins();
    pinSelf     = 1'($urandom);
    pinPartner  = 1'($urandom);
    schmSelf    = 1'($urandom);
    schmPartner = 1'($urandom);
    cmpGt       = 1'($urandom);
    coreOut     = 1'($urandom);
    coreDir     = 1'($urandom);
  endtask

  // one clock: inputs set at negedge, compare before posedge, advance model at posedge
  task automatic stepCycle(string overTag);
    int  code;
    bit  ret, iInv, oInv, inNow, outNow, expIn, expOut, expOe, flt;
    string inTag, outTag;
    #(CLK_PERIOD/4);
    code = int'(cfgWord[11:9]);
    ret  = cfgWord[8];
    iInv = cfgWord[7];
    oInv = cfgWord[6];
    inNow  = selSource(code) ^ iInv;
    outNow = coreOut ^ oInv;
    expIn  = ret ? modelIn : inNow;
    expOut = isLoop(code) ? (expIn ^ oInv) : (ret ? modelOut : outNow);
    flt    = expOut ? (cfgWord[5:3] == 3'b111) : (cfgWord[2:0] == 3'b111);
    expOe  = coreDir && !flt;
    if (overTag != "") begin inTag = overTag; outTag = overTag; end
    else begin
      if (ret) inTag = "R8";
      else if (iInv) inTag = "R6";
      else if (code < 3) inTag = "R2";
      else if (code < 6) inTag = "R3";
      else inTag = "R4";
      if (ret && !isLoop(code)) outTag = "R8";
      else if (oInv) outTag = "R7";
      else outTag = "R5";
    end
    check(inTag, "coreIn", int'(coreIn), int'(expIn));
    check(outTag, "padOut", int'(padOut), int'(expOut));
    check((overTag != "") ? overTag : "R9", "padOe", int'(padOe), int'(expOe));
    check((overTag != "") ? overTag : "R10", "driveHigh", int'(driveHigh), int'(cfgWord[5:3]));
    check((overTag != "") ? overTag : "R10", "driveLow", int'(driveLow), int'(cfgWord[2:0]));
    @(posedge clk);
    modelIn  = inNow;
    modelOut = outNow;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    failCount++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset with retime on, code 000, every input high
    cfgWord = 13'b0_000_100_000000;
    pinSelf = 1; pinPartner = 1; schmSelf = 1; schmPartner = 1; cmpGt = 1; coreOut = 1; coreDir = 1;
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    check("R1", "coreIn in reset", int'(coreIn), 0);
    check("R1", "padOut in reset", int'(padOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    modelIn = 0; modelOut = 0;
    check("R1", "coreIn after reset", int'(coreIn), 0);

    // directed sweep over every source code and every C/I/O combination
    for (int code = 0; code < 8; code++) begin
      for (int ctl = 0; ctl < 8; ctl++) begin
        cfgWord = {1'b0, 3'(code), 3'(ctl), 3'($urandom), 3'($urandom)};
        for (int k = 0; k < 12; k++) begin
          driveRandomPins();
          stepCycle("");
        end
      end
    end

    // float codes: high only, low only, both (R9)
    for (int f = 0; f < 3; f++) begin
      cfgWord = {1'b0, 3'b000, 3'b000, (f != 1) ? 3'b111 : 3'b000, (f != 0) ? 3'b111 : 3'b000};
      for (int k = 0; k < 20; k++) begin
        driveRandomPins();
        stepCycle("");
      end
    end

    // random configuration every cycle, including retime toggling (R8)
    for (int k = 0; k < 3000; k++) begin
      cfgWord = {1'b0, 12'($urandom)};
      driveRandomPins();
      stepCycle("");
    end

    // R11: mode bit set, every output must match the digital-mode model
    for (int k = 0; k < 400; k++) begin
      cfgWord = {1'b1, 12'($urandom)};
      driveRandomPins();
      stepCycle("R11");
    end

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule